// File: doc/BRIEF.md
# Serial EEPROM Target Model

This block behaves like a byte-wide serial EEPROM on an SPI bus in mode 0. Inside one frame, which lasts while the active-low chip select is held low, a controller sends a one-byte instruction. Some instructions are followed by a big-endian address of `ADDR_BYTES` bytes. The block then streams out array or status bytes, or collects write data. The array is a register memory of `MEM_BYTES` bytes. Writes are collected in a page buffer of `PAGE_BYTES` slots and are written to the array only when chip select rises. After that, a busy counter of `BUSY_CYCLES` clock cycles models the internal programming time.

All activity runs on the system clock `clk`. The serial clock, chip select and data input are sampled with edge detection, so the serial clock must stay at least three system clocks in each phase. When `NINE_BIT` is set (used with `ADDR_BYTES` = 1 and 512 bytes), bit 3 of the read and write instructions supplies address bit 8.

The control state machine has these states:
- ST_IDLE: chip select is high.
- ST_OPCODE: an instruction byte is being received.
- ST_ADDR: address bytes are being collected.
- ST_RDATA: array bytes are streamed out.
- ST_WDATA: write bytes are buffered.
- ST_SRD: status bytes are streamed out.
- ST_SWR: a new status value is received.
- ST_IGNORE: the rest of the frame is discarded.

Its transitions are:
- Chip select high sends any state to ST_IDLE.
- ST_IDLE goes to ST_OPCODE once chip select is low.
- At the end of the instruction byte, ST_OPCODE goes to ST_ADDR, ST_SRD, ST_SWR or ST_IGNORE.
- After the last address byte, ST_ADDR goes to ST_RDATA or ST_WDATA.

Top module: `spi_eeprom_target`

## Requirements
- R1: SPI mode 0. `mosi` is sampled on the rising edge of `sclk`. `miso` changes after falling edges. Bytes travel most significant bit first. `miso` is 0 whenever `cs_n` is high.
- R2: Instruction 0x06 sets the write-enable latch and 0x04 clears it. Each takes effect at the end of the instruction byte.
- R3: Instruction 0x05 returns the status byte repeatedly until chip select rises. The status byte is laid out as follows: bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protect level, bit 7 is the protect-enable flag, and bits 6:4 read 0. After reset the status byte is 0x00.
- R4: Instruction 0x03, followed by an address sent most significant byte first, returns consecutive array bytes for as long as chip select is low. After the last address the read wraps to address 0.
- R5: A write instruction (0x02) or status-write instruction (0x01) sent while the write-enable latch is clear has no effect.
- R6: Successive write bytes go to successive addresses, wrapping inside the page of `PAGE_BYTES` bytes that holds the start address.
- R7: Write data reaches the array only when chip select rises, and only for whole bytes. A frame that carries no whole data byte commits nothing and starts no busy period.
- R8: A commit makes status bit 0 read 1 for `BUSY_CYCLES` clocks. During that time every instruction except 0x05 is ignored, and an ignored frame drives 0x00 on `miso`.
- R9: The write-enable latch stays set while busy and clears when the busy period ends.
- R10: Instruction 0x01 followed by one data byte loads bits 7, 3 and 2 into the status byte when chip select rises. The other bits of that data byte are dropped.
- R11: Protect level 1 blocks writes to the top quarter of the array, level 2 to the top half, and level 3 to the whole array. Blocked bytes are silently dropped.
- R12: With `NINE_BIT` set, instructions 0x0B and 0x0A read and write the upper 256 bytes. Instructions 0x03 and 0x02 reach the lower 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select, frames a transaction |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |

## Verification
The assertions check four rules on every cycle:
- An instruction byte that arrives while busy can only lead to ST_SRD or ST_IGNORE.
- The write-enable latch is clear on the cycle the busy period ends.
- A busy period starts only right after chip select rises.
- ST_WDATA is never occupied while the latch is clear.

The bench's scenarios show the behaviours that are visible only as bytes on `miso`:
- the array contents read back;
- page wrap;
- discarded partial bytes;
- protect-level filtering;
- the status format;
- the upper-half addressing of the nine-bit mode.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_SRD,
        ST_SWR,
        ST_IGNORE
    } ee_state_e;
endpackage

// File: rtl/spi_ee_shift.sv
module spi_ee_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       miso
);
    logic       sclk_q;
    logic [2:0] bcnt;
    logic [6:0] sh;
    logic [7:0] tx_sh;
    logic       miso_r;
    logic       rise, fall;

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
    assign miso = miso_r & ~cs_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            bcnt      <= '0;
            sh        <= '0;
            tx_sh     <= '0;
            miso_r    <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            sclk_q    <= sclk;
            byte_done <= 1'b0;
            if (cs_n) begin
                bcnt   <= '0;
                miso_r <= 1'b0;
            end else begin
                if (rise) begin
                    sh   <= {sh[5:0], mosi};
                    bcnt <= bcnt + 3'd1;
                    if (bcnt == 3'd7) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {sh, mosi};
                    end
                end
                if (fall) begin
                    if (bcnt == 3'd0) begin
                        miso_r <= tx_byte[7];
                        tx_sh  <= {tx_byte[6:0], 1'b0};
                    end else begin
                        miso_r <= tx_sh[7];
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_ee_busy.sv
module spi_ee_busy #(
    parameter int BUSY_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(BUSY_CYCLES);
        else if (busy)
            cnt <= cnt - CW'(1);
    end
endmodule

// File: rtl/spi_ee_protect.sv
module spi_ee_protect #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    level,
    output logic          hit
);
    always_comb begin
        unique case (level)
            2'd0: hit = 1'b0;
            2'd1: hit = (addr[AW-1:AW-2] == 2'b11);
            2'd2: hit = addr[AW-1];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_eeprom_target.sv
module spi_eeprom_target
    import spi_ee_pkg::*;
#(
    parameter int MEM_BYTES   = 256,
    parameter int PAGE_BYTES  = 16,
    parameter int ADDR_BYTES  = 2,
    parameter bit NINE_BIT    = 1'b0,
    parameter int BUSY_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    localparam int AW   = $clog2(MEM_BYTES);
    localparam int PW   = $clog2(PAGE_BYTES);
    localparam int ACCW = 8 * ADDR_BYTES;

    ee_state_e state_q, state_d, dec_state;

    logic            byte_done;
    logic [7:0]      rx_byte, tx_byte, op_eff, status, sr_data;
    logic            busy, busy_done, start_busy;
    logic            wel, wpen, cs_q, cs_rise, sr_seen, hi_bit;
    logic [1:0]      bp;
    logic [1:0]      abyte;
    logic            last_abyte;
    logic [ACCW-1:0] acc, acc_next;
    logic [AW-1:0]   a_full, addr;
    logic [PW-1:0]   pidx;
    logic [AW-PW-1:0] pbase;
    logic [PAGE_BYTES-1:0] pvalid, hit;
    logic            commit_wr, commit_sr, rd_mode;
    logic [7:0]      mem  [MEM_BYTES];
    logic [7:0]      pbuf [PAGE_BYTES];
    logic [AW-1:0]   slot_addr [PAGE_BYTES];

    spi_ee_shift u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .tx_byte(tx_byte), .byte_done(byte_done), .rx_byte(rx_byte), .miso(miso)
    );

    spi_ee_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start_busy), .busy(busy), .done(busy_done)
    );

    genvar g;
    generate
        for (g = 0; g < PAGE_BYTES; g++) begin : g_slot
            assign slot_addr[g] = {pbase, PW'(g)};
            spi_ee_protect #(.AW(AW)) u_prot (
                .addr(slot_addr[g]), .level(bp), .hit(hit[g])
            );
        end
        if (NINE_BIT) begin : g_nine
            assign a_full = {hi_bit, acc_next[AW-2:0]};
        end else begin : g_wide
            assign a_full = acc_next[AW-1:0];
        end
    endgenerate

    assign status     = {wpen, 3'b000, bp, wel, busy};
    assign op_eff     = NINE_BIT ? (rx_byte & 8'hF7) : rx_byte;
    assign acc_next   = (ACCW == 8) ? ACCW'(rx_byte) : ACCW'({acc, rx_byte});
    assign last_abyte = (abyte == 2'(ADDR_BYTES - 1));
    assign cs_rise    = cs_n & ~cs_q;
    assign commit_wr  = cs_rise && (state_q == ST_WDATA) && (|pvalid);
    assign commit_sr  = cs_rise && (state_q == ST_SWR) && sr_seen;
    assign start_busy = commit_wr | commit_sr;

    // Instruction decode: which state follows the instruction byte
    always_comb begin
        dec_state = ST_IGNORE;
        if (busy) begin
            if (op_eff == OP_RDSR) dec_state = ST_SRD;
        end else begin
            unique case (op_eff)
                OP_RDSR:  dec_state = ST_SRD;
                OP_WRSR:  dec_state = wel ? ST_SWR : ST_IGNORE;
                OP_READ:  dec_state = ST_ADDR;
                OP_WRITE: dec_state = wel ? ST_ADDR : ST_IGNORE;
                default:  dec_state = ST_IGNORE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: if (byte_done) state_d = dec_state;
                ST_ADDR:   if (byte_done && last_abyte)
                               state_d = rd_mode ? ST_RDATA : ST_WDATA;
                default:   state_d = state_q;
            endcase
        end
    end

    // Datapath and output byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            wel     <= 1'b0;
            wpen    <= 1'b0;
            bp      <= '0;
            tx_byte <= '0;
            rd_mode <= 1'b0;
            hi_bit  <= 1'b0;
            abyte   <= '0;
            acc     <= '0;
            addr    <= '0;
            pidx    <= '0;
            pbase   <= '0;
            pvalid  <= '0;
            sr_data <= '0;
            sr_seen <= 1'b0;
        end else begin
            cs_q <= cs_n;
            if (busy_done) wel <= 1'b0;
            if (cs_rise) begin
                pvalid  <= '0;
                sr_seen <= 1'b0;
                if (commit_sr) begin
                    bp   <= sr_data[3:2];
                    wpen <= sr_data[7];
                end
            end
            if (byte_done && !cs_n) begin
                unique case (state_q)
                    ST_OPCODE: begin
                        if (!busy && op_eff == OP_WREN) wel <= 1'b1;
                        if (!busy && op_eff == OP_WRDI) wel <= 1'b0;
                        rd_mode <= (op_eff == OP_READ);
                        hi_bit  <= rx_byte[3];
                        abyte   <= '0;
                        acc     <= '0;
                        tx_byte <= (dec_state == ST_SRD) ? status : 8'h00;
                    end
                    ST_ADDR: begin
                        acc   <= acc_next;
                        abyte <= abyte + 2'd1;
                        if (last_abyte) begin
                            addr    <= a_full + AW'(1);
                            tx_byte <= rd_mode ? mem[a_full] : 8'h00;
                            pidx    <= a_full[PW-1:0];
                            pbase   <= a_full[AW-1:PW];
                        end
                    end
                    ST_RDATA: begin
                        tx_byte <= mem[addr];
                        addr    <= addr + AW'(1);
                    end
                    ST_WDATA: begin
                        pvalid[pidx] <= 1'b1;
                        pidx         <= pidx + PW'(1);
                    end
                    ST_SRD:  tx_byte <= status;
                    ST_SWR: begin
                        sr_data <= rx_byte;
                        sr_seen <= 1'b1;
                    end
                    default: tx_byte <= 8'h00;
                endcase
            end
        end
    end

    // Page buffer and array storage (no reset)
    always_ff @(posedge clk) begin
        if (state_q == ST_WDATA && byte_done && !cs_n)
            pbuf[pidx] <= rx_byte;
    end

    always_ff @(posedge clk) begin
        if (commit_wr) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (pvalid[i] && !hit[i]) mem[slot_addr[i]] <= pbuf[i];
        end
    end
endmodule

// File: rtl/spi_eeprom_target_chk.sv
module spi_eeprom_target_chk
    import spi_ee_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_n,
    input logic      busy,
    input logic      wel,
    input logic      byte_done,
    input ee_state_e state
);
    AST_BUSY_GATES_OPCODES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_done && !cs_n && state == ST_OPCODE) |=>
            (state == ST_SRD || state == ST_IGNORE || cs_n)); // R8

    AST_WEL_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R9

    AST_BUSY_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_n) && !$past(cs_n, 2))); // R7

    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA) |-> wel); // R5
endmodule

bind spi_eeprom_target spi_eeprom_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy), .wel(wel),
    .byte_done(byte_done), .state(state_q)
);

// File: tb/sim_spi_eeprom_target.sv
module sim_spi_eeprom_target;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic cs0 = 1'b1;
    logic cs1 = 1'b1;
    logic miso0, miso1, miso_sel;
    logic sel = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign miso_sel = sel ? miso1 : miso0;

    spi_eeprom_target #(.MEM_BYTES(256), .PAGE_BYTES(16), .ADDR_BYTES(2),
                        .NINE_BIT(1'b0), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs0), .mosi(mosi), .miso(miso0));

    spi_eeprom_target #(.MEM_BYTES(512), .PAGE_BYTES(16), .ADDR_BYTES(1),
                        .NINE_BIT(1'b1), .BUSY_CYCLES(BUSY)) u1 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs1), .mosi(mosi), .miso(miso1));

    // {address, write data}; each is written then read back
    localparam logic [23:0] VEC [6] = '{
        24'h0003_11, 24'h0060_A7, 24'h0080_3C,
        24'h00C5_E1, 24'h00FE_5D, 24'h0010_99
    };

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk) mosi = tx[7-i];
            repeat (3) @(negedge clk);
            rx = {rx[6:0], miso_sel};
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic fstart();
        @(negedge clk);
        if (sel) cs1 = 1'b0; else cs0 = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic fend();
        repeat (2) @(negedge clk);
        cs0 = 1'b1;
        cs1 = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_addr(input logic [15:0] a);
        logic [7:0] d;
        if (!sel) xfer(a[15:8], 8, d);
        xfer(a[7:0], 8, d);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        fstart(); xfer(op, 8, d); fend();
    endtask

    task automatic read_sr(output logic [7:0] s);
        logic [7:0] d;
        fstart(); xfer(8'h05, 8, d); xfer(8'h00, 8, s); fend();
    endtask

    task automatic write_sr(input logic [7:0] v);
        logic [7:0] d;
        fstart(); xfer(8'h01, 8, d); xfer(v, 8, d); fend();
    endtask

    task automatic write1(input logic [7:0] op, input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        fstart(); xfer(op, 8, d); send_addr(a); xfer(v, 8, d); fend();
    endtask

    task automatic read1(input logic [7:0] op, input logic [15:0] a, output logic [7:0] v);
        logic [7:0] d;
        fstart(); xfer(op, 8, d); send_addr(a); xfer(8'h00, 8, v); fend();
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        for (int k = 0; k < 12; k++) begin
            read_sr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic wr_ok(input logic [15:0] a, input logic [7:0] v);
        cmd(8'h06); write1(8'h02, a, v); wait_ready();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL R8 watchdog actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] s, v, v2, v3, d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: miso quiet with chip select high; R3: reset status
        chk("R1 miso idle", {7'b0, miso0}, 8'h00);
        read_sr(s); chk("R3 reset status", s, 8'h00);

        // R2: latch set and clear
        cmd(8'h06); read_sr(s); chk("R2 WREN status", s, 8'h02);
        cmd(8'h04); read_sr(s); chk("R2 WRDI status", s, 8'h00);

        // R4: table of single-byte writes read back
        for (int k = 0; k < 6; k++) begin
            wr_ok(VEC[k][23:8], VEC[k][7:0]);
            read1(8'h03, VEC[k][23:8], v);
            chk("R4 table readback", v, VEC[k][7:0]);
        end

        // R4: sequential read wraps past the last address
        wr_ok(16'h00FF, 8'h77);
        wr_ok(16'h0000, 8'h88);
        fstart(); xfer(8'h03, 8, d); send_addr(16'h00FE);
        xfer(8'h00, 8, v); xfer(8'h00, 8, v2); xfer(8'h00, 8, v3); fend();
        chk("R4 seq byte0", v, 8'h5D);
        chk("R4 seq byte1", v2, 8'h77);
        chk("R4 seq wrap", v3, 8'h88);

        // R5: write without latch is ignored
        write1(8'h02, 16'h0003, 8'hFF);
        read_sr(s); chk("R5 no busy", s, 8'h00);
        read1(8'h03, 16'h0003, v); chk("R5 data kept", v, 8'h11);

        // R6: burst wraps inside its page
        cmd(8'h06);
        fstart(); xfer(8'h02, 8, d); send_addr(16'h002E);
        xfer(8'hA1, 8, d); xfer(8'hA2, 8, d); xfer(8'hA3, 8, d); fend();
        wait_ready();
        read1(8'h03, 16'h002E, v); chk("R6 first", v, 8'hA1);
        read1(8'h03, 16'h002F, v); chk("R6 second", v, 8'hA2);
        read1(8'h03, 16'h0020, v); chk("R6 wrapped", v, 8'hA3);

        // R7: partial bytes discarded
        cmd(8'h06);
        fstart(); xfer(8'h02, 8, d); send_addr(16'h0050);
        xfer(8'h6B, 8, d); xfer(8'hFF, 3, d); fend();
        wait_ready();
        read1(8'h03, 16'h0050, v); chk("R7 whole byte", v, 8'h6B);
        cmd(8'h06);
        fstart(); xfer(8'h02, 8, d); send_addr(16'h0060); xfer(8'hC3, 5, d); fend();
        read_sr(s); chk("R7 no commit", s, 8'h02);
        read1(8'h03, 16'h0060, v); chk("R7 data kept", v, 8'hA7);
        cmd(8'h04);

        // R8 / R9: busy window
        cmd(8'h06); write1(8'h02, 16'h0010, 8'h42);
        read_sr(s); chk("R8 busy status", s, 8'h03);
        read1(8'h03, 16'h0010, v); chk("R8 read ignored", v, 8'h00);
        wait_ready();
        read_sr(s); chk("R9 latch cleared", s, 8'h00);
        read1(8'h03, 16'h0010, v); chk("R4 after busy", v, 8'h42);

        // R10: status write
        cmd(8'h06); write_sr(8'h8C);
        read_sr(s); chk("R10 status busy", s, 8'h8F);
        wait_ready();
        read_sr(s); chk("R10 status done", s, 8'h8C);
        cmd(8'h06); write_sr(8'h73); wait_ready();
        read_sr(s); chk("R10 masked bits", s, 8'h00);
        write_sr(8'h0C);
        read_sr(s); chk("R5 status write ignored", s, 8'h00);

        // R11: protect levels
        cmd(8'h06); write_sr(8'h04); wait_ready();
        wr_ok(16'h00C5, 8'h12);
        read1(8'h03, 16'h00C5, v); chk("R11 quarter blocked", v, 8'hE1);
        wr_ok(16'h0070, 8'h3D);
        read1(8'h03, 16'h0070, v); chk("R11 lower open", v, 8'h3D);
        cmd(8'h06); write_sr(8'h08); wait_ready();
        wr_ok(16'h0080, 8'h00);
        read1(8'h03, 16'h0080, v); chk("R11 half blocked", v, 8'h3C);
        wr_ok(16'h007F, 8'h9E);
        read1(8'h03, 16'h007F, v); chk("R11 below half", v, 8'h9E);
        cmd(8'h06); write_sr(8'h00); wait_ready();

        // R12: nine-bit addressing on the second instance
        sel = 1'b1;
        cmd(8'h06); write1(8'h0A, 16'h0005, 8'h5A); wait_ready();
        cmd(8'h06); write1(8'h02, 16'h0005, 8'hA5); wait_ready();
        read1(8'h0B, 16'h0005, v); chk("R12 upper half", v, 8'h5A);
        read1(8'h03, 16'h0005, v); chk("R12 lower half", v, 8'hA5);
        sel = 1'b0;

        summary();
    end
endmodule